// File: doc/BRIEF.md
# Serial Link Timebase and Enable Controller

This block supplies the time reference for a byte-level serial bus peripheral running at 10.4 kbit/s variable pulse width. The system clock must be a whole number of megahertz. A prescaler divides that clock by a programmable factor and produces a one-cycle `bit_tick` strobe. In normal operation the strobe comes once per microsecond. Two interval timers count these strobes. One times the 300 µs break symbol and the other times the 1 ms transmitter timeout. Each timer reports its end with a one-cycle pulse.

A diagnostic fast mode lets software run the link four times faster. Software sets the fast bit and writes a smaller divider in the same write, so the tick comes four times as often. The timers then count four times as many ticks, which keeps the break and the timeout at their nominal absolute lengths.

The block holds two 8-bit registers on a simple synchronous write bus with combinational read data. The clock-select register sits at address 0 and the control register at address 1. The control register holds the link enable and a disable interlock. When the enable falls, the block emits a one-cycle abort for any queued transmit. While the link is disabled, the line output stays passive and the line input is ignored.

Top module: `vpw_timebase`

## Requirements
- R1: Reset sets the clock-select register to 00h and the control register to 40h. After reset `link_en` and `tx_abort` are 0.
- R2: Clock-select register (address 0) layout: bit 7 is the fast bit, bits 5:0 are the divider DIV, and bit 6 always reads 0.
- R3: `bit_tick` is high for one cycle in every DIV+1 clock cycles.
- R4: Any write to address 0 restarts the prescaler. The first tick after the write comes DIV+1 cycles after the write edge, using the new DIV.
- R5: Control register (address 1) layout: bit 7 is the enable, bit 6 is the disable, and bits 5:0 read back exactly as last written.
- R6: A control write sets the enable only when its bit 7 is 1, its bit 6 is 0 and the disable bit was already 0 before the write. A write that clears the disable and sets the enable together leaves the enable at 0.
- R7: A control write with bit 6 set clears the enable. A write with bit 7 clear also clears the enable.
- R8: When `link_en` falls, `tx_abort` is high for exactly that one cycle. `tx_abort` is never high at any other time.
- R9: While `link_en` is 0, `line_tx_out` and `line_rx_out` are 0. While it is 1, each of them follows its input with one register of delay.
- R10: The break timer ends with a one-cycle `brk_done` after 300 ticks in normal mode and after 1200 ticks in fast mode.
- R11: The timeout timer ends with a one-cycle `tmo_done` after 1000 ticks in normal mode and after 4000 ticks in fast mode.
- R12: While `link_en` is 0, both timers are held idle, so a start is ignored. Dropping the enable during a run cancels the run, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, a whole number of MHz |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 clock select, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| line_tx_req | input | 1 | Transmit level requested by the symbol encoder |
| line_rx_in | input | 1 | Receive level from the bus |
| line_tx_out | output | 1 | Gated transmit level, passive 0 when disabled |
| line_rx_out | output | 1 | Gated receive level, 0 when disabled |
| brk_start | input | 1 | Starts (or restarts) the break timer |
| tmo_start | input | 1 | Starts (or restarts) the timeout timer |
| bit_tick | output | 1 | Prescaled time tick |
| brk_done | output | 1 | One-cycle end-of-break pulse |
| tmo_done | output | 1 | One-cycle end-of-timeout pulse |
| link_en | output | 1 | Link enable to transmitter and receiver |
| tx_abort | output | 1 | One-cycle abort for a queued transmit |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data follows combinationally. The bench therefore reads back one drive step after each write. `link_en` and `tx_abort` change at that same write edge, so the bench samples them in the following cycle before the next edge. The gated line outputs carry one more register, so the bench checks them one clock later. The tick scoreboard receives expected gaps of DIV+1 cycles from the driver and measures each gap from the write edge or from the previous tick. Timer lengths are checked by counting the ticks seen after the start edge up to the cycle in which the done pulse appears.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  localparam int REG_W = 8;
  localparam logic ADDR_CLKSEL = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;
  localparam logic [REG_W-1:0] CTRL_RST = 8'h40;
  localparam int NUM_TIMERS = 2;
  localparam int FAST_SCALE = 4;
endpackage

// File: rtl/vpw_prescaler.sv
module vpw_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/vpw_interval.sv
module vpw_interval #(
  parameter int BASE_TICKS = 300,
  parameter int SCALE      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic fast,
  input  logic start,
  input  logic tick,
  output logic done
);
  localparam int MAX_TICKS = BASE_TICKS * SCALE;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] LIM_NORM = CW'(BASE_TICKS - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(MAX_TICKS - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fast ? LIM_FAST : LIM_NORM;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && tick) begin
        if (cnt == lim) begin
          busy <= 1'b0;
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vpw_regs.sv
module vpw_regs
  import vpw_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             fast,
  output logic [DIV_W-1:0] div,
  output logic             reload,
  output logic             en,
  output logic             dis,
  output logic             abort
);
  localparam int AUX_W = REG_W - 2;
  localparam int PAD_W = REG_W - 1 - DIV_W;

  logic [AUX_W-1:0] aux;
  logic             ctl_wr;
  logic             en_next;

  assign ctl_wr  = we && (addr == ADDR_CTRL);
  assign reload  = we && (addr == ADDR_CLKSEL);
  assign en_next = wdata[REG_W-1] & ~wdata[REG_W-2] & ~dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast  <= 1'b0;
      div   <= '0;
      en    <= CTRL_RST[REG_W-1];
      dis   <= CTRL_RST[REG_W-2];
      aux   <= CTRL_RST[AUX_W-1:0];
      abort <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (reload) begin
        fast <= wdata[REG_W-1];
        div  <= wdata[DIV_W-1:0];
      end
      if (ctl_wr) begin
        en    <= en_next;
        dis   <= wdata[REG_W-2];
        aux   <= wdata[AUX_W-1:0];
        abort <= en & ~en_next;
      end
    end
  end

  always_comb begin
    if (addr == ADDR_CLKSEL) rdata = {fast, {PAD_W{1'b0}}, div};
    else                     rdata = {en, dis, aux};
  end
endmodule

// File: rtl/vpw_timebase.sv
module vpw_timebase
  import vpw_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int BREAK_US   = 300,
  parameter int TIMEOUT_US = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             line_tx_req,
  input  logic             line_rx_in,
  output logic             line_tx_out,
  output logic             line_rx_out,
  input  logic             brk_start,
  input  logic             tmo_start,
  output logic             bit_tick,
  output logic             brk_done,
  output logic             tmo_done,
  output logic             link_en,
  output logic             tx_abort
);
  localparam int LENS [NUM_TIMERS] = '{BREAK_US, TIMEOUT_US};

  logic             cfg_fast;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_reload;
  logic             ctl_dis;
  logic [NUM_TIMERS-1:0] t_start;
  logic [NUM_TIMERS-1:0] t_done;

  vpw_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .fast(cfg_fast), .div(cfg_div), .reload(cfg_reload),
    .en(link_en), .dis(ctl_dis), .abort(tx_abort)
  );

  vpw_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .reload(cfg_reload), .div(cfg_div), .tick(bit_tick)
  );

  assign t_start = {tmo_start, brk_start};

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    vpw_interval #(.BASE_TICKS(LENS[i]), .SCALE(FAST_SCALE)) u_tmr (
      .clk(clk), .rst(rst), .hold(!link_en), .fast(cfg_fast),
      .start(t_start[i]), .tick(bit_tick), .done(t_done[i])
    );
  end

  assign brk_done = t_done[0];
  assign tmo_done = t_done[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx_out <= 1'b0;
      line_rx_out <= 1'b0;
    end else begin
      line_tx_out <= link_en & line_tx_req;
      line_rx_out <= link_en & line_rx_in;
    end
  end
endmodule

// File: rtl/vpw_timebase_chk.sv
module vpw_timebase_chk (
  input logic       clk,
  input logic       rst,
  input logic       link_en,
  input logic       ctl_dis,
  input logic       tx_abort,
  input logic       line_tx_out,
  input logic       line_rx_out,
  input logic       brk_done,
  input logic       tmo_done,
  input logic       bus_addr,
  input logic [7:0] bus_rdata
);
  AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 1'b0) |-> !bus_rdata[6]); // R2
  AST_EN_NEEDS_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(link_en) |-> !$past(ctl_dis)); // R6
  AST_DIS_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    ctl_dis |-> !link_en); // R7
  AST_ABORT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(link_en) |-> tx_abort); // R8
  AST_ABORT_ONLY_FALL: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> $fell(link_en)); // R8
  AST_LINE_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(link_en) |-> (!line_tx_out && !line_rx_out)); // R9
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (rst)
    brk_done |=> !brk_done); // R10
  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (rst)
    tmo_done |=> !tmo_done); // R11
  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    !$past(link_en) |-> (!brk_done && !tmo_done)); // R12
endmodule

bind vpw_timebase vpw_timebase_chk u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .ctl_dis(ctl_dis),
  .tx_abort(tx_abort), .line_tx_out(line_tx_out), .line_rx_out(line_rx_out),
  .brk_done(brk_done), .tmo_done(tmo_done), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/vpw_timebase_test.sv
`timescale 1ns/1ps
module vpw_timebase_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       line_tx_req = 1'b0, line_rx_in = 1'b0;
  logic       line_tx_out, line_rx_out;
  logic       brk_start = 1'b0, tmo_start = 1'b0;
  logic       bit_tick, brk_done, tmo_done, link_en, tx_abort;

  int checks = 0;
  int errors = 0;
  int gap = 0;
  int exp_gap[$];

  always #2.5 clk = ~clk;

  vpw_timebase uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_tx_req(line_tx_req),
    .line_rx_in(line_rx_in), .line_tx_out(line_tx_out), .line_rx_out(line_rx_out),
    .brk_start(brk_start), .tmo_start(tmo_start), .bit_tick(bit_tick),
    .brk_done(brk_done), .tmo_done(tmo_done), .link_en(link_en), .tx_abort(tx_abort)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  // Tick scoreboard monitor: gaps measured from a clock-select write or the previous tick
  always @(negedge clk) begin
    if (bus_we && bus_addr == 1'b0) gap = -1;
    else begin
      gap++;
      if (bit_tick) begin
        if (exp_gap.size() > 0) chk("R3/R4 tick gap", gap, exp_gap.pop_front());
        gap = 0;
      end
    end
  end

  task automatic set_div(logic fast, int n);
    wr(1'b0, {fast, 1'b0, 6'(n)});
    repeat (3) exp_gap.push_back(n + 1);
    repeat (4 * (n + 1) + 2) @(posedge clk);
    chk("R3 scoreboard drained", exp_gap.size(), 0);
  endtask

  task automatic measure(bit which, int exp, string tag);
    int n = 0;
    bit seen = 0;
    @(posedge clk); #1;
    if (which) tmo_start = 1'b1; else brk_start = 1'b1;
    @(posedge clk); #1;
    tmo_start = 1'b0; brk_start = 1'b0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      @(negedge clk);
      if ((which ? tmo_done : brk_done) == 1'b1) seen = 1;
      else if (bit_tick) n++;
    end
    chk({tag, " ticks"}, n, exp);
    @(negedge clk);
    chk({tag, " done one cycle"}, int'(which ? tmo_done : brk_done), 0);
  endtask

  task automatic no_done(int cycles, string tag);
    int hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (brk_done || tmo_done) hits++;
    end
    chk(tag, hits, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(1'b0, d); chk("R1 clksel reset", d, 8'h00);
    rd(1'b1, d); chk("R1 control reset", d, 8'h40);
    chk("R1 link_en reset", link_en, 0);
    chk("R1 abort reset", tx_abort, 0);
    // R2 reserved bit reads zero
    wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 clksel readback", d, 8'hBF);
    // R3 R4 tick period with reload
    set_div(1'b0, 3);
    set_div(1'b0, 7);
    set_div(1'b0, 0);
    // R5 R6 interlock
    wr(1'b1, 8'hAA); rd(1'b1, d); chk("R6 clear dis and set en together", d, 8'h2A);
    chk("R6 link_en stays low", link_en, 0);
    wr(1'b1, 8'h95); rd(1'b1, d); chk("R5 control readback", d, 8'h95);
    chk("R6 link_en set", link_en, 1);
    // R9 line gating while enabled
    line_tx_req = 1'b1; line_rx_in = 1'b1;
    @(posedge clk); #1;
    chk("R9 tx follows", line_tx_out, 1);
    chk("R9 rx follows", line_rx_out, 1);
    // R10 R11 normal mode, DIV=0
    measure(1'b0, 300, "R10 break normal");
    measure(1'b1, 1000, "R11 timeout normal");
    // R10 normal with DIV=3
    set_div(1'b0, 3);
    measure(1'b0, 300, "R10 break normal div3");
    // R10 R11 fast mode
    wr(1'b0, 8'h80); rd(1'b0, d); chk("R2 fast bit readback", d, 8'h80);
    measure(1'b0, 1200, "R10 break fast");
    measure(1'b1, 4000, "R11 timeout fast");
    wr(1'b0, 8'h00);
    // R7 R8 disable bit drops enable with abort
    wr(1'b1, 8'hC0);
    chk("R7 link_en cleared by dis", link_en, 0);
    chk("R8 abort pulse", tx_abort, 1);
    @(posedge clk); #1;
    chk("R8 abort one cycle", tx_abort, 0);
    chk("R9 tx passive", line_tx_out, 0);
    chk("R9 rx ignored", line_rx_out, 0);
    // R12 start ignored while disabled
    @(posedge clk); #1; brk_start = 1'b1; tmo_start = 1'b1;
    @(posedge clk); #1; brk_start = 1'b0; tmo_start = 1'b0;
    no_done(1100, "R12 start ignored when disabled");
    // R7 write with bit7 clear, R12 cancel mid-run
    wr(1'b1, 8'h00); wr(1'b1, 8'h80);
    chk("R6 enable after dis low", link_en, 1);
    @(posedge clk); #1; brk_start = 1'b1;
    @(posedge clk); #1; brk_start = 1'b0;
    repeat (100) @(posedge clk);
    wr(1'b1, 8'h00);
    chk("R7 link_en cleared by write 0", link_en, 0);
    chk("R8 abort on software clear", tx_abort, 1);
    no_done(400, "R12 run cancelled");
    wr(1'b1, 8'h00);
    chk("R8 no abort when already low", tx_abort, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule